// File: doc/BRIEF.md
# Frame Double Buffer with Bank-Select Swap

This block places two equal storage banks between a sample stream and a consumer that works on whole frames. The producer side is a valid/ready stream. A beat transfers on a clock edge where both `s_tvalid` and `s_tready` are high. The producer must hold `s_tdata` and `s_tlast` steady while `s_tvalid` is high and `s_tready` is low. The block lowers `s_tready` only while a finished frame waits for the consumer to give up its bank.

Beats fill the producer's bank from address zero upward. The consumer reads the other bank at any address, in any order, through a synchronous read port. A frame closes in one of two ways. The usual way is a beat carrying `s_tlast`. The other way is that the bank runs out of room, which sets a truncation flag. Once a frame has closed and the consumer has released its bank, a single select bit toggles in one cycle. The two banks swap roles and no data is copied. The consumer is told the frame length, which may be shorter than a full bank.

Top module: `pingpong_frame_buf`

## Requirements
- R1: After reset the producer owns bank 0 (`wr_bank`=0), `frame_valid` is 0, `s_tready` is 1, and no frame is waiting.
- R2: Accepted beats are stored in the producer's bank at consecutive addresses, starting at address 0 after reset and after every swap.
- R3: Accepting a beat with `s_tlast`=1 closes the frame. From the next cycle `s_tready` stays 0 until the swap takes place, so no beat is lost or overwritten.
- R4: A closed frame is handed over on the first clock edge where `frame_valid` is 0. On that single edge `wr_bank` toggles, `frame_valid` rises and `s_tready` returns to 1.
- R5: `rd_data` gives the consumer bank's word at the `rd_addr` sampled on the previous clock edge, a latency of one cycle.
- R6: `frame_done` sampled high while `frame_valid` is 1 makes `frame_valid` fall on the next edge. `frame_done` has no effect while `frame_valid` is 0.
- R7: A frame closed by `s_tlast` after N beats (1 ≤ N ≤ DEPTH) reports `frame_len`=N and `frame_trunc`=0.
- R8: When DEPTH beats have been accepted without `s_tlast`, the frame closes anyway and reports `frame_len`=DEPTH and `frame_trunc`=1. The next beat starts a new frame.
- R9: While the consumer holds a frame, the producer fills the other bank. The held frame's contents, `frame_len` and `wr_bank` stay unchanged until the consumer releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W | Sample word |
| s_tvalid | input | 1 | Producer has a beat |
| s_tready | output | 1 | Block can take a beat |
| s_tlast | input | 1 | Beat is the last of its frame |
| rd_addr | input | ADDR_W | Consumer read address |
| rd_data | output | DATA_W | Consumer read data, one cycle after the address |
| frame_valid | output | 1 | The consumer bank holds a complete frame |
| frame_done | input | 1 | Consumer releases its frame |
| frame_len | output | LEN_W | Number of words in the held frame |
| frame_trunc | output | 1 | Held frame was closed by a full bank, not by `s_tlast` |
| wr_bank | output | 1 | Bank currently owned by the producer |

## Verification
Most internal faults show up at the ports within one or two cycles. A select bit that flips at the wrong time shows up as `wr_bank` moving without a rising `frame_valid`. It also shows up as consumer reads returning words from the frame now being filled. A stuck closed state keeps `s_tready` low after the swap edge. A write address that fails to restart is caught when a later frame is read back from address 0. A wrong length count shows up in `frame_len` on the cycle `frame_valid` rises.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Producer-side state of the write bank
  typedef enum logic {
    WR_FILLING = 1'b0,
    WR_CLOSED  = 1'b1
  } wr_state_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              sel,
  input  logic              rel,
  output logic              held,
  output logic [LEN_W-1:0]  held_len,
  output logic              held_trunc
);
  wr_state_e        st;
  logic [LEN_W-1:0] pend_len;
  logic             pend_trunc;
  logic             at_end;

  assign in_ready = (st == WR_FILLING);
  assign wr_en    = in_valid && in_ready;
  assign at_end   = (wr_addr == ADDR_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= WR_FILLING;
      sel        <= 1'b0;
      wr_addr    <= '0;
      held       <= 1'b0;
      held_len   <= '0;
      held_trunc <= 1'b0;
      pend_len   <= '0;
      pend_trunc <= 1'b0;
    end else begin
      if (held && rel) held <= 1'b0;
      case (st)
        WR_FILLING: begin
          if (wr_en) begin
            if (in_last || at_end) begin
              st         <= WR_CLOSED;
              pend_len   <= LEN_W'(wr_addr) + LEN_W'(1);
              pend_trunc <= !in_last;
            end else begin
              wr_addr <= wr_addr + ADDR_W'(1);
            end
          end
        end
        WR_CLOSED: begin
          if (!held) begin
            sel        <= ~sel;
            st         <= WR_FILLING;
            wr_addr    <= '0;
            held       <= 1'b1;
            held_len   <= pend_len;
            held_trunc <= pend_trunc;
          end
        end
        default: st <= WR_FILLING;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_frame_buf.sv
module pingpong_frame_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              frame_valid,
  input  logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              frame_trunc,
  output logic              wr_bank
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              sel;
  logic              rd_bank_q;
  logic [DATA_W-1:0] bank_rdata [2];

  pp_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (s_tvalid),
    .in_last    (s_tlast),
    .in_ready   (s_tready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .sel        (sel),
    .rel        (frame_done),
    .held       (frame_valid),
    .held_len   (frame_len),
    .held_trunc (frame_trunc)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_bank (
      .clk   (clk),
      .we    (wr_en && (sel == 1'(b))),
      .waddr (wr_addr),
      .wdata (s_tdata),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );
  end

  // Remember which bank the registered read came from
  always_ff @(posedge clk) begin
    if (!rst_n) rd_bank_q <= 1'b1;
    else        rd_bank_q <= ~sel;
  end

  assign rd_data = bank_rdata[rd_bank_q];
  assign wr_bank = sel;
endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
  parameter int DEPTH = 1024,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_tvalid,
  input logic             s_tready,
  input logic             s_tlast,
  input logic             frame_valid,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_len,
  input logic             wr_bank
);
  // R3
  stall_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> !s_tready);

  // R4
  swap_with_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> !$stable(wr_bank));

  // R4
  no_stray_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_bank) |-> $rose(frame_valid));

  // R6
  release_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_done) |=> !frame_valid);

  // R9
  held_frame_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_done) |=> (frame_valid && $stable(frame_len) && $stable(wr_bank)));

  // R7
  len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len != '0 && frame_len <= LEN_W'(DEPTH)));
endmodule

bind pingpong_frame_buf pp_chk #(.DEPTH(DEPTH)) i_pp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_tvalid    (s_tvalid),
  .s_tready    (s_tready),
  .s_tlast     (s_tlast),
  .frame_valid (frame_valid),
  .frame_done  (frame_done),
  .frame_len   (frame_len),
  .wr_bank     (wr_bank)
);

// File: tb/test_pingpong_frame_buf.sv
module test_pingpong_frame_buf;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic          s_tlast = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          frame_valid;
  logic          frame_done = 1'b0;
  logic [LW-1:0] frame_len;
  logic          frame_trunc;
  logic          wr_bank;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pingpong_frame_buf #(.DATA_W(DW), .DEPTH(DEPTH)) i_pingpong_frame_buf (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tlast(s_tlast), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_valid(frame_valid), .frame_done(frame_done), .frame_len(frame_len),
    .frame_trunc(frame_trunc), .wr_bank(wr_bank)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, input logic last);
    @(negedge clk);
    s_tdata = d; s_tlast = last; s_tvalid = 1'b1;
    while (!s_tready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic read_word(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic release_frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic check_frame(input string req, input int n, input logic [DW-1:0] base);
    logic [DW-1:0] d;
    for (int i = 0; i < n; i++) begin
      read_word(i, d);
      check(req, d, base + DW'(i));
    end
  endtask

  task automatic t_reset();
    check("R1 wr_bank", 32'(wr_bank), 0);
    check("R1 frame_valid", 32'(frame_valid), 0);
    check("R1 s_tready", 32'(s_tready), 1);
  endtask

  task automatic t_full_frame();
    for (int i = 0; i < DEPTH; i++) push(32'h100 + DW'(i), i == DEPTH - 1);
    idle();
    check("R3 tready low after tlast", 32'(s_tready), 0);
    check("R4 valid not yet", 32'(frame_valid), 0);
    @(negedge clk);
    check("R4 frame_valid after swap", 32'(frame_valid), 1);
    check("R4 wr_bank toggled", 32'(wr_bank), 1);
    check("R4 tready restored", 32'(s_tready), 1);
    check("R7 full len", 32'(frame_len), DEPTH);
    check("R7 trunc clear", 32'(frame_trunc), 0);
    check_frame("R5 R2 full frame data", DEPTH, 32'h100);
  endtask

  task automatic t_overlap_short();
    for (int i = 0; i < 5; i++) push(32'h200 + DW'(i), i == 4);
    idle();
    repeat (4) @(negedge clk);
    check("R3 tready held low", 32'(s_tready), 0);
    check("R9 valid held", 32'(frame_valid), 1);
    check("R9 len held", 32'(frame_len), DEPTH);
    check("R9 bank held", 32'(wr_bank), 1);
    check_frame("R9 held data intact", DEPTH, 32'h100);
    release_frame();
    check("R6 valid falls", 32'(frame_valid), 0);
    @(negedge clk);
    check("R4 second swap valid", 32'(frame_valid), 1);
    check("R4 second swap bank", 32'(wr_bank), 0);
    check("R7 short len", 32'(frame_len), 5);
    check("R7 short trunc", 32'(frame_trunc), 0);
    check_frame("R5 short frame data", 5, 32'h200);
    release_frame();
  endtask

  task automatic t_ignore_done();
    release_frame();
    repeat (2) @(negedge clk);
    check("R6 done ignored valid", 32'(frame_valid), 0);
    check("R6 done ignored bank", 32'(wr_bank), 0);
    check("R6 done ignored ready", 32'(s_tready), 1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(32'h300 + DW'(i), 1'b0);
    idle();
    check("R8 closed without tlast", 32'(s_tready), 0);
    @(negedge clk);
    check("R8 valid", 32'(frame_valid), 1);
    check("R8 len", 32'(frame_len), DEPTH);
    check("R8 trunc", 32'(frame_trunc), 1);
    check_frame("R8 data", DEPTH, 32'h300);
    push(32'h4AA, 1'b1);
    idle();
    release_frame();
    @(negedge clk);
    check("R2 restart valid", 32'(frame_valid), 1);
    check("R2 restart len", 32'(frame_len), 1);
    check("R8 next frame trunc clear", 32'(frame_trunc), 0);
    check_frame("R2 restart at zero", 1, 32'h4AA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_frame();
    t_overlap_short();
    t_ignore_done();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule